// File: doc/BRIEF.md
# Multichannel Edge-Aligned PWM Generator

This block drives a bank of PWM output lines from a single up-counting timebase. Every channel compares the shared counter against its own duty value, so all channels run at one common period and differ only in pulse width and polarity. The counter clock can be slowed by a fixed power-of-two prescale that is chosen at elaboration.

Software reaches the block through a one-cycle write port. A write either asks for a new period or sets one channel's duty and polarity. Channel values land in a shadow copy first. They move into the active copy at the first counter wrap after a synchronization strobe. A period change is applied at once: it restarts the counter and forces that load. A per-pair capture-armed input locks writes out. A write to an armed pair is refused, and so is any period change while any pair is armed. Rejected or refused writes raise a one-cycle error or busy flag.

Top module: `pwm_bank`

## Requirements
- R1: The counter starts at 0 after reset with a period of 65535. It counts 0, 1, ..., period-1 and wraps to 0, and it is shared by all channels.
- R2: A configured channel in normal polarity (polarity bit 0) drives high while the counter is below its duty value and low otherwise. A duty greater than or equal to the period gives a constant high.
- R3: A configured channel in inverted polarity (polarity bit 1) drives the exact complement of R2.
- R4: After reset every channel is unconfigured with duty 0 and drives low. It stays low until a write to it has been loaded into the active copy.
- R5: A period write (wr_sel = 0) with data 0 or above 65535 raises wr_err in the next cycle and changes nothing.
- R6: A valid period write whose value differs from the current period has three effects on the next edge: the period is replaced, the counter is set to 0 and every channel's shadow is loaded into its active copy. A write of the value already in force has no effect.
- R7: A channel write (wr_sel = 1) updates only the shadow. The shadow reaches the outputs at the edge where the counter wraps from period-1 to 0, provided sync_req was pulsed on or before that edge and after the previous load.
- R8: A channel write with wr_chan at or beyond the channel count raises wr_err in the next cycle and changes nothing. An error takes priority over busy.
- R9: A channel write to channel c while cap_armed[c/2] is set raises wr_busy in the next cycle and is discarded.
- R10: A valid period write of a different value while any cap_armed bit is set raises wr_busy in the next cycle and leaves the period and counter running unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_sel | input | 1 | 0 = period write, 1 = channel write |
| wr_chan | input | CHW | Channel index for a channel write |
| wr_data | input | CW+1 | Period request or duty value (duty uses the low CW bits) |
| wr_inv | input | 1 | Polarity bit for a channel write, 1 = inverted |
| sync_req | input | 1 | Synchronization strobe for shadow loading |
| cap_armed | input | NPAIR | Capture-armed flag per channel pair |
| pwm_out | output | NCH | One PWM line per channel |
| wr_err | output | 1 | Pulse: last write was rejected |
| wr_busy | output | 1 | Pulse: last write was refused due to capture |

## Verification
The bench predicts every output cycle from a model of the requirements. It aims at the cases that are easy to get wrong.

A duty equal to or above the period must stay high through the wrap. A design with an off-by-one compare would drop one cycle. A duty of 0 must stay low. Shadow writes made without a strobe must stay invisible for several full periods. A design that loads on every wrap would show the new width early. A period request of exactly 65536 exercises the width limit, and a truncating design would accept it as 0.

The capture lockout is tested on both the armed and the unarmed pair. Rewriting the same period while armed must raise nothing. The forced load on a period change is checked on the very next cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic {
      SEL_PERIOD = 1'b0,
      SEL_CHAN   = 1'b1
   } pwm_sel_e;

   // Output level of one channel given its compare result and state.
   function automatic logic pwm_level(input logic cfg, input logic below,
                                      input logic inv);
      return cfg & (below ^ inv);
   endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int unsigned PRESC_LOG2 = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (PRESC_LOG2 == 0) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = PRESC_LOG2;
         logic [PW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   div_q <= '0;
            else if (clr) div_q <= '0;
            else          div_q <= div_q + 1'b1;
         end
         assign tick = &div_q;
      end
   endgenerate
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          per_wr,
   input  logic [CW-1:0] per_val,
   input  logic          sync_req,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] period,
   output logic          load
);
   localparam logic [CW-1:0] RST_PERIOD = {CW{1'b1}};

   logic pend_q;
   logic wrap;
   logic pend_eff;

   assign pend_eff = pend_q | sync_req;
   assign wrap     = tick & ~per_wr & (cnt == period - 1'b1);
   assign load     = per_wr | (wrap & pend_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         period <= RST_PERIOD;
         pend_q <= 1'b0;
      end else if (per_wr) begin
         cnt    <= '0;
         period <= per_val;
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_eff & ~wrap;
         if (wrap)      cnt <= '0;
         else if (tick) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_pkg::*;
#(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW-1:0] wr_duty,
   input  logic          wr_inv,
   input  logic          load,
   input  logic [CW-1:0] cnt,
   output logic          pwm
);
   logic [CW-1:0] sh_duty, act_duty;
   logic          sh_inv, act_inv, sh_cfg, act_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_duty <= '0;
         sh_inv  <= 1'b0;
         sh_cfg  <= 1'b0;
      end else if (wr) begin
         sh_duty <= wr_duty;
         sh_inv  <= wr_inv;
         sh_cfg  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_duty <= '0;
         act_inv  <= 1'b0;
         act_cfg  <= 1'b0;
      end else if (load) begin
         act_duty <= sh_duty;
         act_inv  <= sh_inv;
         act_cfg  <= sh_cfg;
      end
   end

   assign pwm = pwm_level(act_cfg, cnt < act_duty, act_inv);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_pkg::*;
#(
   parameter int unsigned NCH        = 4,
   parameter int unsigned CW         = 16,
   parameter int unsigned PRESC_LOG2 = 0,
   localparam int unsigned CHW   = $clog2(NCH) + 1,
   localparam int unsigned NPAIR = (NCH + 1) / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CHW-1:0]   wr_chan,
   input  logic [CW:0]      wr_data,
   input  logic             wr_inv,
   input  logic             sync_req,
   input  logic [NPAIR-1:0] cap_armed,
   output logic [NCH-1:0]   pwm_out,
   output logic             wr_err,
   output logic             wr_busy
);
   localparam logic [CW:0] MAX_PER = {1'b0, {CW{1'b1}}};

   if (NCH < 1 || NCH > 64) begin : g_chk_nch
      $error("pwm_bank: NCH out of range");
   end
   if (CW < 2 || CW > 31) begin : g_chk_cw
      $error("pwm_bank: CW out of range");
   end
   if (PRESC_LOG2 > 16) begin : g_chk_presc
      $error("pwm_bank: PRESC_LOG2 out of range");
   end

   logic [CW-1:0] cnt, period;
   logic          tick, load;
   logic          per_req, per_bad, per_diff, per_wr, per_busy;
   logic          ch_req, ch_bad, ch_busy, ch_ok;
   logic [NCH-1:0] ch_wr;

   // Period request decode
   assign per_req  = wr_en & (wr_sel == SEL_PERIOD);
   assign per_bad  = (wr_data == '0) | (wr_data > MAX_PER);
   assign per_diff = wr_data[CW-1:0] != period;
   assign per_busy = per_req & ~per_bad & per_diff & (|cap_armed);
   assign per_wr   = per_req & ~per_bad & per_diff & ~(|cap_armed);

   // Channel request decode
   assign ch_req = wr_en & (wr_sel == SEL_CHAN);
   assign ch_bad = {{(32-CHW){1'b0}}, wr_chan} >= NCH;

   always_comb begin
      ch_busy = 1'b0;
      for (int p = 0; p < NPAIR; p++) begin
         if ({{(32-CHW){1'b0}}, wr_chan} >> 1 == p && cap_armed[p])
            ch_busy = 1'b1;
      end
   end

   assign ch_ok = ch_req & ~ch_bad & ~ch_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_err  <= 1'b0;
         wr_busy <= 1'b0;
      end else begin
         wr_err  <= (per_req & per_bad) | (ch_req & ch_bad);
         wr_busy <= per_busy | (ch_req & ~ch_bad & ch_busy);
      end
   end

   pwm_prescale #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (per_wr),
      .tick  (tick)
   );

   pwm_timebase #(.CW(CW)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .per_wr   (per_wr),
      .per_val  (wr_data[CW-1:0]),
      .sync_req (sync_req),
      .cnt      (cnt),
      .period   (period),
      .load     (load)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_wr[c] = ch_ok && ({{(32-CHW){1'b0}}, wr_chan} == c);
      pwm_channel #(.CW(CW)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (ch_wr[c]),
         .wr_duty (wr_data[CW-1:0]),
         .wr_inv  (wr_inv),
         .load    (load),
         .cnt     (cnt),
         .pwm     (pwm_out[c])
      );
   end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 16,
   localparam int unsigned CHW   = $clog2(NCH) + 1,
   localparam int unsigned NPAIR = (NCH + 1) / 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_sel,
   input logic [CHW-1:0]   wr_chan,
   input logic [CW:0]      wr_data,
   input logic [NPAIR-1:0] cap_armed,
   input logic             wr_err,
   input logic             wr_busy,
   input logic [CW-1:0]    cnt,
   input logic [CW-1:0]    period
);
   localparam logic [CW:0] MAXP = {1'b0, {CW{1'b1}}};

   logic pair_armed;
   logic chan_oob;
   logic per_ok;

   always_comb begin
      pair_armed = 1'b0;
      for (int p = 0; p < NPAIR; p++)
         if (int'(wr_chan) / 2 == p && cap_armed[p]) pair_armed = 1'b1;
   end
   assign chan_oob = int'(wr_chan) >= NCH;
   assign per_ok   = (wr_data != '0) && (wr_data <= MAXP);

   a_r1_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < period);

   a_r5_bad_period: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !per_ok) |=> (wr_err && $stable(period)));

   a_r6_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && per_ok && wr_data[CW-1:0] != period && cap_armed == '0)
      |=> (cnt == '0 && period == $past(wr_data[CW-1:0])));

   a_r8_bad_chan: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && chan_oob) |=> (wr_err && !wr_busy));

   a_r9_pair_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !chan_oob && pair_armed) |=> (wr_busy && !wr_err));

   a_r10_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && per_ok && wr_data[CW-1:0] != period && cap_armed != '0)
      |=> (wr_busy && $stable(period)));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (.*);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
   localparam int NCH = 4;
   localparam int CW  = 16;
   localparam int CHW = 3;
   localparam int NP  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0, wr_sel = 1'b0, wr_inv = 1'b0, sync_req = 1'b0;
   logic [CHW-1:0] wr_chan = '0;
   logic [CW:0]    wr_data = '0;
   logic [NP-1:0]  cap_armed = '0;
   logic [NCH-1:0] pwm_out;
   logic           wr_err, wr_busy;

   always #2.5 clk = ~clk;

   pwm_bank u_pwm_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_chan(wr_chan), .wr_data(wr_data), .wr_inv(wr_inv),
      .sync_req(sync_req), .cap_armed(cap_armed), .pwm_out(pwm_out),
      .wr_err(wr_err), .wr_busy(wr_busy)
   );

   typedef struct {
      logic [NCH-1:0] pwm;
      logic           err;
      logic           busy;
      string          tag;
   } exp_t;

   exp_t  q[$];
   int    n_chk = 0, n_bad = 0;
   string phase = "R4";
   bit    done = 0;

   // Requirement model
   int m_cnt = 0, m_per = 65535;
   bit m_pend = 0;
   int sh_d[NCH], ac_d[NCH];
   bit sh_i[NCH], ac_i[NCH], sh_c[NCH], ac_c[NCH];

   initial begin
      for (int c = 0; c < NCH; c++) begin
         sh_d[c] = 0; ac_d[c] = 0; sh_i[c] = 0; ac_i[c] = 0;
         sh_c[c] = 0; ac_c[c] = 0;
      end
   end

   task automatic model_edge(bit en, bit sel, int chan, int data, bit inv,
                             bit sync, logic [NP-1:0] cap);
      exp_t e;
      int   od[NCH];
      bit   oi[NCH], oc[NCH];
      bit   force_ld = 0, ld = 0;
      e.err = 0; e.busy = 0;
      for (int c = 0; c < NCH; c++) begin od[c] = sh_d[c]; oi[c] = sh_i[c]; oc[c] = sh_c[c]; end
      if (en && !sel) begin
         if (data == 0 || data > 65535) e.err = 1;
         else if (data != m_per) begin
            if (cap != 0) e.busy = 1; else force_ld = 1;
         end
      end
      if (en && sel) begin
         if (chan >= NCH) e.err = 1;
         else if (cap[chan/2]) e.busy = 1;
         else begin sh_d[chan] = data & 16'hFFFF; sh_i[chan] = inv; sh_c[chan] = 1; end
      end
      if (force_ld) begin
         m_per = data; m_cnt = 0; m_pend = 0; ld = 1;
      end else if (m_cnt == m_per - 1) begin
         m_cnt = 0; ld = m_pend | sync; m_pend = 0;
      end else begin
         m_cnt++; m_pend = m_pend | sync;
      end
      if (ld)
         for (int c = 0; c < NCH; c++) begin ac_d[c] = od[c]; ac_i[c] = oi[c]; ac_c[c] = oc[c]; end
      for (int c = 0; c < NCH; c++)
         e.pwm[c] = ac_c[c] & ((m_cnt < ac_d[c]) ^ ac_i[c]);
      e.tag = phase;
      q.push_back(e);
   endtask

   // Driver: one clock of stimulus, expected item queued after the edge
   task automatic step(bit en, bit sel, int chan, int data, bit inv, bit sync);
      wr_en = en; wr_sel = sel; wr_chan = chan[CHW-1:0];
      wr_data = data[CW:0]; wr_inv = inv; sync_req = sync;
      @(posedge clk);
      model_edge(en, sel, chan, data, inv, sync, cap_armed);
      @(negedge clk);
      wr_en = 0; sync_req = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   // Monitor: compares away from the active edge
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (pwm_out !== e.pwm || wr_err !== e.err || wr_busy !== e.busy) begin
            n_bad++;
            $display("FAIL %s: pwm=%b err=%b busy=%b, expected pwm=%b err=%b busy=%b",
                     e.tag, pwm_out, wr_err, wr_busy, e.pwm, e.err, e.busy);
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4 reset state, R1 counter running at reset period
      phase = "R4"; idle(4);
      // R6 period change from reset value
      phase = "R6"; step(1, 0, 0, 8, 0, 0);
      // R7 shadow writes invisible without strobe
      phase = "R7";
      step(1, 1, 0, 3, 0, 0);
      step(1, 1, 1, 5, 1, 0);
      step(1, 1, 2, 9, 0, 0);
      step(1, 1, 3, 0, 0, 0);
      idle(10);
      step(0, 0, 0, 0, 0, 1);
      // R2 normal, R3 inverted, R1 wrap at period 8
      phase = "R2"; idle(10);
      phase = "R3"; idle(10);
      // R8 out-of-range channel
      phase = "R8"; step(1, 1, 5, 2, 0, 0); step(1, 1, 4, 2, 1, 0); idle(2);
      // R5 rejected periods
      phase = "R5"; step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 65536, 0, 0); idle(3);
      // R9 pair lockout
      phase = "R9";
      cap_armed = 2'b01;
      step(1, 1, 1, 2, 0, 1); idle(9);
      cap_armed = 2'b10;
      step(1, 1, 0, 4, 0, 1); idle(9);
      // R10 period lockout, same-period write ignored
      phase = "R10";
      step(1, 0, 0, 6, 0, 0); idle(2);
      step(1, 0, 0, 8, 0, 0); idle(2);
      cap_armed = 2'b00;
      // R7 multiple periods with pending shadow but no strobe
      phase = "R7";
      step(1, 1, 0, 6, 0, 0); step(1, 1, 3, 7, 1, 0); idle(20);
      // R6 forced load on period change
      phase = "R6"; step(1, 0, 0, 6, 0, 0); idle(14);
      phase = "R6"; step(1, 0, 0, 65535, 0, 0); idle(4);
      phase = "R6"; step(1, 0, 0, 5, 0, 0); idle(12);
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule